// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt sources and presents them to a processor through a small register window. Each source is sampled every clock. A source that is high sets a pending flag, and the flag stays set after the source drops. A mask register selects which pending sources may raise the single interrupt request line. Software changes the mask through separate enable and disable command offsets, so a write never disturbs bits it did not name. Pending flags are retired through a clear command or an end-of-interrupt command.

Reading the vector offset acknowledges an interrupt. The read returns the index of the lowest-numbered pending source, whether or not that source is masked. The same clock edge drops that pending flag and records the index in a last-vector register, which software can read back later. A read of the vector offset with nothing pending returns zero and changes no flag.

The bus is a single-cycle select/write strobe pair with a byte address. Read data and its valid flag come back one clock after the read is presented. The interrupt request is a register that follows the masked pending state with one clock of delay.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, the pending, mask and last-vector registers are zero, `irq_req` is 0, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: A source bit that is high at a clock edge sets its pending flag at that edge. If a clear, end-of-interrupt or vector acknowledge targets the same bit at the same edge, the set wins.
- R3: A write to offset 0x120 ORs `bus_wdata` into the mask. A read of offset 0x110 returns the mask.
- R4: A write to offset 0x124 clears in the mask every bit that is 1 in `bus_wdata`.
- R5: A write to offset 0x128 clears in the pending register every bit that is 1 in `bus_wdata`.
- R6: A write to offset 0x130 (end of interrupt) clears in the pending register every bit that is 1 in `bus_wdata`.
- R7: A read (`bus_sel`=1, `bus_wr`=0) of offset 0x100 returns, on the next cycle with `bus_rvalid`=1, the index of the lowest-numbered pending bit. The mask plays no part in this choice.
- R8: The vector read of R7 clears the returned pending bit at the same edge that captures the read data.
- R9: A vector read with no bit pending returns 0 and leaves the pending register unchanged.
- R10: A read of offset 0x108 returns the value produced by the most recent vector read, including a 0 from an empty read. It returns 0 if no vector read has happened since reset.
- R11: After each clock edge out of reset, `irq_req` equals the OR of (pending AND mask) as those registers stood before that edge.
- R12: A read of any other offset, including the command offsets, returns 0 with `bus_rvalid`=1. A write to any other offset changes nothing. `bus_rvalid` and `bus_rdata` are 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | NSRC (32) | Interrupt source levels, sampled every edge |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (9) | Byte offset of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default 32 sources and a 32-bit data path. With these values every source index from 0 to 31 can be reached, including the highest one, where the index fills the full 5-bit field. Directed sequences cover the set-over-clear race, the one-cycle lag of the request line, the empty vector read and the acknowledge order when several sources are pending. A long random phase then runs sparse source pulses against all command offsets and stray offsets, while a behavioural model compares every output on every cycle.

// File: rtl/irq_vec_pkg.sv
// Package: shared constants and types of the vectored interrupt controller.
// Assumes byte offsets fit in 9 bits; offsets are the software-visible map.
package irq_vec_pkg;
    localparam logic [8:0] OFF_VEC  = 9'h100;
    localparam logic [8:0] OFF_LAST = 9'h108;
    localparam logic [8:0] OFF_MASK = 9'h110;
    localparam logic [8:0] OFF_EN   = 9'h120;
    localparam logic [8:0] OFF_DIS  = 9'h124;
    localparam logic [8:0] OFF_CLR  = 9'h128;
    localparam logic [8:0] OFF_EOI  = 9'h130;

    // Decoded one-cycle command strobes.
    typedef struct packed {
        logic en;
        logic dis;
        logic clr;
        logic eoi;
        logic rd;
        logic rd_vec;
        logic rd_last;
        logic rd_mask;
    } cmd_t;
endpackage

// File: rtl/irq_vec_decode.sv
// Module: turns one bus access into command strobes.
// Assumes at most one access per cycle; unmatched offsets give no strobe
// except the generic read strobe.
module irq_vec_decode #(
    parameter int AW = 9
) (
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    output irq_vec_pkg::cmd_t    cmd
);
    import irq_vec_pkg::*;

    logic wr_s;
    logic rd_s;

    assign wr_s = bus_sel & bus_wr;
    assign rd_s = bus_sel & ~bus_wr;

    // Purpose: compare the offset against each command location.
    always_comb begin
        cmd         = '0;
        cmd.rd      = rd_s;
        cmd.en      = wr_s && (bus_addr == AW'(OFF_EN));
        cmd.dis     = wr_s && (bus_addr == AW'(OFF_DIS));
        cmd.clr     = wr_s && (bus_addr == AW'(OFF_CLR));
        cmd.eoi     = wr_s && (bus_addr == AW'(OFF_EOI));
        cmd.rd_vec  = rd_s && (bus_addr == AW'(OFF_VEC));
        cmd.rd_last = rd_s && (bus_addr == AW'(OFF_LAST));
        cmd.rd_mask = rd_s && (bus_addr == AW'(OFF_MASK));
    end
endmodule

// File: rtl/irq_vec_scan.sv
// Module: finds the lowest-numbered set bit of the pending vector.
// Assumes NSRC >= 2; idx is 0 when nothing is set.
module irq_vec_scan #(
    parameter int NSRC = 32,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    // Purpose: walk from the top down so the lowest set bit is left last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_pending.sv
// Module: per-source pending flags.
// Assumes set and clear vectors are aligned bit for bit; set wins.
module irq_vec_pending #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] pend_q
);
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        // Purpose: hold one pending flag; a set overrides a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[b] <= 1'b0;
            else if (set_vec[b])
                pend_q[b] <= 1'b1;
            else if (clr_vec[b])
                pend_q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
// Module: top of the vectored interrupt controller.
// Holds mask, last-vector, read-data and request registers; pending flags,
// decode and priority scan live in submodules. Assumes NSRC <= DW and one
// bus access per cycle.
module irq_vec_ctrl #(
    parameter int NSRC = 32,
    parameter int DW   = 32,
    parameter int AW   = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_rvalid,
    output logic            irq_req
);
    import irq_vec_pkg::*;

    localparam int IDXW = $clog2(NSRC);

    cmd_t            cmd;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;
    logic [IDXW-1:0] last_q;
    logic [NSRC-1:0] wbits;
    logic [NSRC-1:0] ack_vec;
    logic [NSRC-1:0] clr_vec;
    logic [IDXW-1:0] scan_idx;
    logic            scan_any;
    logic [IDXW-1:0] vec_val;
    logic [DW-1:0]   rd_mux;
    logic [DW-1:0]   rdata_q;
    logic            rvalid_q;
    logic            irq_q;

    irq_vec_decode #(.AW(AW)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .cmd      (cmd)
    );

    irq_vec_scan #(.NSRC(NSRC)) u_scan (
        .pend (pend_q),
        .any  (scan_any),
        .idx  (scan_idx)
    );

    irq_vec_pending #(.NSRC(NSRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (src_lvl),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    assign wbits   = bus_wdata[NSRC-1:0];
    assign vec_val = scan_any ? scan_idx : '0;

    // Purpose: gather every clear source for the pending flags.
    always_comb begin
        ack_vec = '0;
        if (cmd.rd_vec && scan_any)
            ack_vec[scan_idx] = 1'b1;
        clr_vec = ack_vec | ((cmd.clr || cmd.eoi) ? wbits : '0);
    end

    // Purpose: select the read value for the addressed offset.
    always_comb begin
        rd_mux = '0;
        if (cmd.rd_vec)
            rd_mux = DW'(vec_val);
        else if (cmd.rd_last)
            rd_mux = DW'(last_q);
        else if (cmd.rd_mask)
            rd_mux = DW'(mask_q);
    end

    // Purpose: update mask, last vector, read response and request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            last_q   <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q    <= |(pend_q & mask_q);
            mask_q   <= (mask_q | (cmd.en ? wbits : '0)) & ~(cmd.dis ? wbits : '0);
            rvalid_q <= cmd.rd;
            rdata_q  <= rd_mux;
            if (cmd.rd_vec)
                last_q <= vec_val;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign irq_req    = irq_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
// Checker: temporal properties of irq_vec_ctrl, attached by bind.
module irq_vec_ctrl_chk #(
    parameter int NSRC = 32,
    parameter int DW   = 32,
    parameter int AW   = 9,
    localparam int IDXW = $clog2(NSRC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_lvl,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic            bus_rvalid,
    input logic            irq_req,
    input logic [NSRC-1:0] pend_q,
    input logic [NSRC-1:0] mask_q,
    input logic [IDXW-1:0] last_q
);
    import irq_vec_pkg::*;

    logic run_q;
    logic rd_vec_s;

    // Purpose: mark that one edge out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    assign rd_vec_s = bus_sel && !bus_wr && (bus_addr == AW'(OFF_VEC));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && mask_q == '0 && last_q == '0 && !irq_req && !bus_rvalid));

    // R2
    src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lvl != '0) |=> ((pend_q & $past(src_lvl)) == $past(src_lvl)));

    // R3
    enable_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'(OFF_EN))
        |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    // R4
    disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'(OFF_DIS))
        |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));

    // R7
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    // R8
    ack_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec_s && pend_q != '0 && src_lvl == '0)
        |=> ($countones(pend_q) + 1 == $past($countones(pend_q))));

    // R9
    empty_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec_s && pend_q == '0) |=> (bus_rdata == '0 && last_q == '0));

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (irq_req == $past(|(pend_q & mask_q))));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_lvl    (src_lvl),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq_req    (irq_req),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .last_q     (last_q)
);

// File: tb/irq_vec_ctrl_tb.sv
// Bench: directed sequences plus a random phase, checked each cycle
// against a behavioural model.
module irq_vec_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference model.
    logic [31:0] m_pend, m_mask, m_last, m_rdata;
    logic        m_rvalid, m_irq;
    string       m_tag = "R1";

    always @(posedge clk) begin
        logic [31:0] clrv;
        int v;
        if (!rst_n) begin
            m_pend = 0; m_mask = 0; m_last = 0; m_rdata = 0;
            m_rvalid = 0; m_irq = 0; m_tag = "R1";
        end else begin
            m_irq = |(m_pend & m_mask);
            clrv = 0;
            m_rvalid = 0;
            m_rdata = 0;
            if (bus_sel && !bus_wr) begin
                m_rvalid = 1;
                m_tag = "R12";
                if (bus_addr == 9'h100) begin
                    v = -1;
                    for (int i = 0; i < 32; i++)
                        if (v < 0 && m_pend[i]) v = i;
                    if (v < 0) begin
                        m_rdata = 0; m_tag = "R9";
                    end else begin
                        m_rdata = v; clrv[v] = 1'b1; m_tag = "R7";
                    end
                    m_last = m_rdata;
                end else if (bus_addr == 9'h108) begin
                    m_rdata = m_last; m_tag = "R10";
                end else if (bus_addr == 9'h110) begin
                    m_rdata = m_mask; m_tag = "R3";
                end
            end else if (bus_sel && bus_wr) begin
                case (bus_addr)
                    9'h120: m_mask = m_mask | bus_wdata;
                    9'h124: m_mask = m_mask & ~bus_wdata;
                    9'h128, 9'h130: clrv = bus_wdata;
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~clrv) | src_lvl;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11", {31'b0, irq_req}, {31'b0, m_irq});
            chk(m_tag, {31'b0, bus_rvalid}, {31'b0, m_rvalid});
            chk(m_tag, bus_rdata, m_rdata);
        end
    end

    // One bus cycle driven at a falling edge; returns at the next one.
    task automatic step(input logic s, input logic w, input logic [8:0] a,
                        input logic [31:0] d, input logic [31:0] src);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; src_lvl = src;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; src_lvl = '0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        step(1, 0, a, 0, 0);
        d = bus_rdata;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        repeat (4) @(negedge clk);
        // R1: reset state visible at the ports
        chk("R1", {31'b0, irq_req}, 32'd0);
        chk("R1", {31'b0, bus_rvalid}, 32'd0);
        rst_n = 1'b1;
        rd(9'h110, d); chk("R1", d, 32'd0);
        rd(9'h108, d); chk("R1", d, 32'd0);
        rd(9'h100, d); chk("R9", d, 32'd0);

        // R7 / R8: lowest index first, each read retires one flag
        step(0, 0, 0, 0, (32'd1 << 9) | (32'd1 << 2) | (32'd1 << 31));
        rd(9'h100, d); chk("R7", d, 32'd2);
        rd(9'h100, d); chk("R8", d, 32'd9);
        rd(9'h100, d); chk("R8", d, 32'd31);
        rd(9'h108, d); chk("R10", d, 32'd31);
        rd(9'h100, d); chk("R9", d, 32'd0);
        rd(9'h108, d); chk("R10", d, 32'd0);

        // R2: set beats a clear of the same bit
        step(1, 1, 9'h128, 32'd1 << 4, 32'd1 << 4);
        rd(9'h100, d); chk("R2", d, 32'd4);
        // R5: clear command drops a pending flag
        step(0, 0, 0, 0, 32'd1 << 7);
        wr(9'h128, 32'd1 << 7);
        rd(9'h100, d); chk("R5", d, 32'd0);
        // R6: end-of-interrupt drops a pending flag
        step(0, 0, 0, 0, 32'd1 << 8);
        wr(9'h130, 32'd1 << 8);
        rd(9'h100, d); chk("R6", d, 32'd0);

        // R3 / R4: mask set and cleared by command offsets
        wr(9'h120, 32'h0000_00F0);
        wr(9'h120, 32'h0000_000F);
        rd(9'h110, d); chk("R3", d, 32'h0000_00FF);
        wr(9'h124, 32'h0000_003C);
        rd(9'h110, d); chk("R4", d, 32'h0000_00C3);

        // R11: request lags the masked pending state by one edge
        step(0, 0, 0, 0, 32'd1);
        chk("R11", {31'b0, irq_req}, 32'd0);
        step(0, 0, 0, 0, 0);
        chk("R11", {31'b0, irq_req}, 32'd1);
        wr(9'h128, 32'd1);
        chk("R11", {31'b0, irq_req}, 32'd1);
        step(0, 0, 0, 0, 0);
        chk("R11", {31'b0, irq_req}, 32'd0);
        // R7: masked-off source is still returned by the vector read
        step(0, 0, 0, 0, 32'd1 << 20);
        rd(9'h100, d); chk("R7", d, 32'd20);
        chk("R11", {31'b0, irq_req}, 32'd0);

        // R12: stray writes and reads have no effect
        wr(9'h100, 32'hFFFF_FFFF);
        wr(9'h110, 32'hFFFF_FFFF);
        wr(9'h1FC, 32'hFFFF_FFFF);
        rd(9'h110, d); chk("R12", d, 32'h0000_00C3);
        rd(9'h120, d); chk("R12", d, 32'd0);
        rd(9'h1FC, d); chk("R12", d, 32'd0);
        rd(9'h100, d); chk("R12", d, 32'd0);

        // Random phase, compared against the model every cycle.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] src, wd;
            logic [8:0]  a;
            int op;
            src = ($urandom % 6 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
            wd  = $urandom & $urandom;
            op  = $urandom % 10;
            case (op)
                0: a = 9'h100;
                1: a = 9'h108;
                2: a = 9'h110;
                3: a = 9'h120;
                4: a = 9'h124;
                5: a = 9'h128;
                6: a = 9'h130;
                7: a = 9'h100;
                default: a = 9'($urandom);
            endcase
            if (op == 9)
                step(0, 0, 0, 0, src);
            else
                step(1, (op >= 3 && op <= 6) || ($urandom % 8 == 0), a, wd, src);
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule